// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block produces the effective address for a four-beat burst in a synchronous burst memory. When a new access starts, a load strobe captures the full access address. The two lowest bits become the start offset of the burst, and the upper bits are held unchanged for the whole burst. Each later clock edge with the active-low advance input asserted moves the burst to its next beat. The effective low bits follow one of two orders, and a mode input picks the order at run time.

A linear order counts upward from the start offset, modulo four. An interleaved order XORs the start offset with the beat number. A beat counter records the burst position. The low address bits are formed from the start offset and that counter in the selected order, and they wrap back to the start offset after the fourth beat. Reads and writes use the same sequence.

Top module: `burst_seq_top`

## Requirements
- R1: After reset, and before any load, `effAddr` is all zeros.
- R2: On the cycle after a clock edge with `loadStb` high, `effAddr` equals the `addrIn` value captured at that edge, which is beat 0 of the burst.
- R3: `advN` has no effect at an edge where `loadStb` is high, so the burst still starts at beat 0.
- R4: With `modeSel` = 0 (linear), `effAddr[1:0]` equals (start + beat) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `modeSel` = 1 (interleaved), `effAddr[1:0]` equals start XOR beat. For example, start 10 gives 10, 11, 00, 01.
- R6: Each clock edge with `loadStb` low and `advN` low advances the beat by one.
- R7: At an edge with `loadStb` low and `advN` high, the beat and the effective address hold their values.
- R8: The beat wraps from 3 to 0, so the fifth beat of a burst repeats the start offset.
- R9: `effAddr[ADDR_W-1:2]` stays equal to the upper bits of the loaded address until the next load.
- R10: A load in the middle of a burst discards that burst and restarts at beat 0 with the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStb | input | 1 | Starts a burst and captures `addrIn` |
| addrIn | input | ADDR_W | Access address; the low 2 bits are the start offset |
| advN | input | 1 | Active-low advance to the next beat |
| modeSel | input | 1 | Burst order: 0 selects linear, 1 selects interleaved |
| effAddr | output | ADDR_W | Effective address of the current beat |

## Verification
Directed bursts start from offsets 01 and 10. They run in both orders, so a linear step cannot be mistaken for an XOR step, and they continue past four beats to expose the wrap. Advance is held high in the middle of a burst to separate a hold from a step. A load issued with advance low shows whether that advance is ignored. A reload in the middle of a burst shows whether the beat restarts. Seeded random runs mix loads, advances and mode flips over random addresses, so wrong upper-bit handling or a skipped beat shows up against the bench's own reference model.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a new address, clear the beat
    logic step;  // advance the beat by one
  } seqStrobe_t;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burstOrder_e;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  logic       advN,
  output seqStrobe_t strb
);

  // A load takes priority; an advance in the same cycle is dropped
  always_comb begin
    strb.load = loadStb;
    strb.step = !loadStb && !advN;
  end

  // R3: a load never coincides with a step
  a_r3_load_blocks_step: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> !strb.step);

  // R6: advance low without a load always produces a step
  a_r6_adv_steps: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !advN) |-> strb.step);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              modeSel,
  output logic [ADDR_W-1:0] effAddr
);

  localparam int UP_W = ADDR_W - LOW_W;

  logic [LOW_W-1:0] startReg;
  logic [LOW_W-1:0] beatCnt;
  logic [LOW_W-1:0] lowLin;
  logic [LOW_W-1:0] lowIlv;
  logic [LOW_W-1:0] lowSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= '0;
      beatCnt  <= '0;
    end else if (strb.load) begin
      startReg <= addrIn[LOW_W-1:0];
      beatCnt  <= '0;
    end else if (strb.step) begin
      beatCnt  <= beatCnt + 1'b1;  // natural wrap at 2**LOW_W
    end
  end

  always_comb begin
    lowLin = startReg + beatCnt;
    lowIlv = startReg ^ beatCnt;
    lowSel = (burstOrder_e'(modeSel) == ORDER_INTERLEAVED) ? lowIlv : lowLin;
  end

  generate
    if (UP_W > 0) begin : g_upper
      logic [UP_W-1:0] upperReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          upperReg <= '0;
        else if (strb.load) upperReg <= addrIn[ADDR_W-1:LOW_W];
      end
      assign effAddr = {upperReg, lowSel};

      // R9: upper bits change only on a load
      a_r9_upper_stable: assert property (@(posedge clk) disable iff (!rstN)
        !strb.load |=> $stable(upperReg));
    end else begin : g_noupper
      assign effAddr = lowSel;
    end
  endgenerate

  // R2: a load leaves the beat at zero
  a_r2_load_clears_beat: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (beatCnt == '0));

  // R6: a step moves the beat on by one
  a_r6_step_incr: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load) |=> (beatCnt == $past(beatCnt) + 1'b1));

  // R7: with no strobe the beat and start offset hold
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.load) |=> ($stable(beatCnt) && $stable(startReg)));

  // R8: the last beat wraps to zero
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load && (beatCnt == '1)) |=> (beatCnt == '0));

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advN,
  input  logic              modeSel,
  output logic [ADDR_W-1:0] effAddr
);

  seqStrobe_t strb;

  burst_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadStb (loadStb),
    .advN    (advN),
    .strb    (strb)
  );

  burst_seq_dp #(
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addrIn  (addrIn),
    .modeSel (modeSel),
    .effAddr (effAddr)
  );

  // R10: after a load the port shows the captured address
  a_r10_load_shows_addr: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && $stable(modeSel)) |=> (effAddr == $past(addrIn)));

  // R10: never both strobes at once
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.step}));

endmodule

// File: tb/sim_burst_seq_top.sv
module sim_burst_seq_top;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadStb = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          advN = 1'b1;
  logic          modeSel = 1'b0;
  logic [AW-1:0] effAddr;

  int total = 0;
  int bad = 0;

  // reference state
  logic [1:0]    mStart = '0;
  logic [1:0]    mBeat = '0;
  logic [AW-3:0] mUpper = '0;

  always #4 clk = ~clk;  // 125 MHz

  burst_seq_top #(.ADDR_W(AW), .LOW_W(2)) u0 (
    .clk (clk), .rstN (rstN), .loadStb (loadStb), .addrIn (addrIn),
    .advN (advN), .modeSel (modeSel), .effAddr (effAddr)
  );

  function automatic logic [AW-1:0] expAddr(input logic mode);
    logic [1:0] lo;
    lo = mode ? (mStart ^ mBeat) : (mStart + mBeat);
    return {mUpper, lo};
  endfunction

  task automatic check(input string req);
    logic [AW-1:0] e;
    e = expAddr(modeSel);
    total++;
    if (effAddr !== e) begin
      bad++;
      $display("FAIL %s: effAddr=%h expected=%h", req, effAddr, e);
    end
  endtask

  // drive on negedge, clock, update model, sample 1 ns after the edge
  task automatic tick(input logic ld, input logic [AW-1:0] a, input logic adv,
                      input logic md, input string req);
    @(negedge clk);
    loadStb = ld; addrIn = a; advN = adv; modeSel = md;
    @(posedge clk);
    if (ld) begin
      mStart = a[1:0]; mUpper = a[AW-1:2]; mBeat = '0;
    end else if (!adv) begin
      mBeat = mBeat + 2'd1;
    end
    #1;
    check(req);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] base;
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1");

    // R4/R8: linear from 01 with wrap
    base = 18'h2A5C1;
    tick(1'b1, base, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 5; i++) tick(1'b0, '0, 1'b0, 1'b0, i == 4 ? "R8" : "R4");

    // R5: interleaved from 10
    base = 18'h13F02;
    tick(1'b1, base, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 4; i++) tick(1'b0, '1, 1'b0, 1'b1, "R5");
    tick(1'b0, '0, 1'b0, 1'b1, "R8");

    // R3: load with advance low stays at beat 0
    tick(1'b1, 18'h00007, 1'b0, 1'b0, "R3");
    // R7: hold, with addrIn changing (R9 upper untouched)
    tick(1'b0, 18'h3FFFF, 1'b0, 1'b0, "R6");
    tick(1'b0, 18'h3FFFF, 1'b1, 1'b0, "R7");
    tick(1'b0, 18'h00000, 1'b1, 1'b0, "R9");
    // R10: reload mid-burst
    tick(1'b1, 18'h1E5A1, 1'b0, 1'b1, "R10");
    tick(1'b0, 18'h0, 1'b0, 1'b1, "R10");

    // seeded random traffic
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      logic ld, ad, md;
      ld = ($urandom % 6) == 0;
      ad = ($urandom % 3) == 0;
      md = ($urandom % 8) == 0 ? ~modeSel : modeSel;
      tick(ld, AW'($urandom), ad, md,
           ld ? "R10" : (ad ? "R7" : (md ? "R5" : "R4")));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule